// File: doc/BRIEF.md
# Highest-priority pending source selector

This block picks the one interrupt source that a single target context should be told about. It takes three bit vectors, one bit per source ID: pending, claimed and enabled. It also takes one priority value per source. That value is the one captured when the source became pending, so the block never reads a live priority register. From these inputs it returns the winning source ID and a valid flag.

The block is purely combinational. Its output is used in two ways: it drives the context's interrupt request line, and it is the value a claim access returns.

A source can win only if it is pending, enabled and not yet claimed. ID 0 is reserved and means "nothing selected". Vector positions at or above the number of implemented IDs are ignored. The winner is the candidate with the highest priority, and among equal priorities the lowest ID wins. A candidate whose priority is 0 still wins when it is the only one.

Top module: `irq_best_sel`

## Requirements
- R1: A source k is a candidate only when pend_i[k]=1, en_i[k]=1 and claim_i[k]=0; any other combination never selects it.
- R2: Bit 0 of every vector is never selected; when no candidate exists, id_o is 0 and valid_o is 0.
- R3: The selected source has a priority (field prio_i[k*PRIO_W +: PRIO_W]) that no other candidate exceeds.
- R4: Among candidates that share the highest priority, the lowest ID is selected.
- R5: A candidate with priority 0 is selected when it is the only candidate, or when every candidate has priority 0 (then the lowest ID wins).
- R6: Vector positions with index at or above NUM_SRC are never selected and do not affect the result, whatever their bits or priorities.
- R7: valid_o is 1 exactly when at least one candidate exists, and valid_o=1 implies id_o is nonzero.
- R8: The outputs depend only on the present inputs: a change of any input is reflected in id_o and valid_o in the same cycle, with no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | VEC_W | Pending bit per source ID |
| claim_i | input | VEC_W | Claimed (in service) bit per source ID |
| en_i | input | VEC_W | Enable bit per source ID for this context |
| prio_i | input | VEC_W*PRIO_W | Priority latched at pend time, source k at bits k*PRIO_W upward |
| id_o | output | $clog2(VEC_W) | Winning source ID, 0 when none |
| valid_o | output | 1 | At least one candidate exists |

## Verification
The selector is first driven with directed patterns, each aimed at a single rule. Single-bit masking cases separate the pending, enable and claimed terms from one another. Equal-priority groups show whether ties go to the lowest ID, and a candidate placed above the winner tests the strictly-greater rule. All-zero priorities check that a priority-0 source still wins, and high-priority stray bits at ID 0 and above NUM_SRC check that those positions are ignored. After the directed cases, random vectors are applied with priorities drawn from a narrow range so that ties are frequent. Every cycle is compared against a behavioural upward scan.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned DEF_VEC_W   = 32;
  localparam int unsigned DEF_NUM_SRC = 24;
  localparam int unsigned DEF_PRIO_W  = 3;

  typedef enum logic {
    PICK_LO = 1'b0,
    PICK_HI = 1'b1
  } pick_e;
endpackage

// File: rtl/irq_cand_mask.sv
module irq_cand_mask #(
  parameter int unsigned VEC_W   = irq_sel_pkg::DEF_VEC_W,
  parameter int unsigned NUM_SRC = irq_sel_pkg::DEF_NUM_SRC
) (
  input  logic [VEC_W-1:0] pend_i,
  input  logic [VEC_W-1:0] claim_i,
  input  logic [VEC_W-1:0] en_i,
  output logic [VEC_W-1:0] cand_o
);
  for (genvar k = 0; k < VEC_W; k++) begin : g_bit
    if (k == 0 || k >= NUM_SRC) begin : g_off
      // reserved ID 0 and unimplemented IDs
      assign cand_o[k] = 1'b0;
    end else begin : g_on
      assign cand_o[k] = pend_i[k] & en_i[k] & ~claim_i[k];
    end
  end
endmodule

// File: rtl/irq_cmp_node.sv
module irq_cmp_node #(
  parameter int unsigned ID_W   = 5,
  parameter int unsigned PRIO_W = irq_sel_pkg::DEF_PRIO_W
) (
  input  logic              lo_vld_i,
  input  logic [ID_W-1:0]   lo_id_i,
  input  logic [PRIO_W-1:0] lo_prio_i,
  input  logic              hi_vld_i,
  input  logic [ID_W-1:0]   hi_id_i,
  input  logic [PRIO_W-1:0] hi_prio_i,
  output logic              vld_o,
  output logic [ID_W-1:0]   id_o,
  output logic [PRIO_W-1:0] prio_o
);
  import irq_sel_pkg::*;

  pick_e pick;

  // upper half replaces lower only on strictly greater priority
  always_comb begin
    pick = PICK_LO;
    if (hi_vld_i && (!lo_vld_i || (hi_prio_i > lo_prio_i))) pick = PICK_HI;
  end

  assign vld_o  = lo_vld_i | hi_vld_i;
  assign id_o   = (pick == PICK_HI) ? hi_id_i   : lo_id_i;
  assign prio_o = (pick == PICK_HI) ? hi_prio_i : lo_prio_i;
endmodule

// File: rtl/irq_best_sel.sv
module irq_best_sel #(
  parameter int unsigned VEC_W   = irq_sel_pkg::DEF_VEC_W,
  parameter int unsigned NUM_SRC = irq_sel_pkg::DEF_NUM_SRC,
  parameter int unsigned PRIO_W  = irq_sel_pkg::DEF_PRIO_W,
  localparam int unsigned ID_W   = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0]        pend_i,
  input  logic [VEC_W-1:0]        claim_i,
  input  logic [VEC_W-1:0]        en_i,
  input  logic [VEC_W*PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]         id_o,
  output logic                    valid_o
);
  localparam int unsigned LVL    = $clog2(VEC_W);
  localparam int unsigned LEAVES = 1 << LVL;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [VEC_W-1:0] cand;

  irq_cand_mask #(.VEC_W(VEC_W), .NUM_SRC(NUM_SRC)) u_mask (
    .pend_i (pend_i),
    .claim_i(claim_i),
    .en_i   (en_i),
    .cand_o (cand)
  );

  // heap layout: node n has children 2n+1 (lower IDs) and 2n+2
  logic              nv [NODES];
  logic [ID_W-1:0]   nid[NODES];
  logic [PRIO_W-1:0] np [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < VEC_W) begin : g_real
      assign nv [LEAVES-1+k] = cand[k];
      assign nid[LEAVES-1+k] = ID_W'(k);
      assign np [LEAVES-1+k] = prio_i[k*PRIO_W +: PRIO_W];
    end else begin : g_pad
      assign nv [LEAVES-1+k] = 1'b0;
      assign nid[LEAVES-1+k] = '0;
      assign np [LEAVES-1+k] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    irq_cmp_node #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_cmp (
      .lo_vld_i (nv [2*n+1]),
      .lo_id_i  (nid[2*n+1]),
      .lo_prio_i(np [2*n+1]),
      .hi_vld_i (nv [2*n+2]),
      .hi_id_i  (nid[2*n+2]),
      .hi_prio_i(np [2*n+2]),
      .vld_o    (nv [n]),
      .id_o     (nid[n]),
      .prio_o   (np [n])
    );
  end

  assign valid_o = nv[0];
  assign id_o    = nv[0] ? nid[0] : '0;

  // checks against the raw inputs, independent of the tree
  logic in_range, win_is_cand, none_higher, none_tied_lower, any_live;
  always_comb begin
    in_range        = (int'(id_o) < NUM_SRC);
    win_is_cand     = pend_i[id_o] & en_i[id_o] & ~claim_i[id_o];
    none_higher     = 1'b1;
    none_tied_lower = 1'b1;
    any_live        = 1'b0;
    for (int k = 1; k < NUM_SRC && k < VEC_W; k++) begin
      if (pend_i[k] && en_i[k] && !claim_i[k]) begin
        any_live = 1'b1;
        if (prio_i[k*PRIO_W +: PRIO_W] > prio_i[int'(id_o)*PRIO_W +: PRIO_W])
          none_higher = 1'b0;
        if (k < int'(id_o) &&
            prio_i[k*PRIO_W +: PRIO_W] == prio_i[int'(id_o)*PRIO_W +: PRIO_W])
          none_tied_lower = 1'b0;
      end
    end
  end

  always_comb begin
    a_r7_valid_nonzero: assert (valid_o == (id_o != '0));
    a_r7_valid_any:     assert (valid_o == any_live);
    if (valid_o) begin
      a_r1_win_cand:    assert (win_is_cand);
      a_r6_win_range:   assert (in_range);
      a_r3_max_prio:    assert (none_higher);
      a_r4_lowest_tie:  assert (none_tied_lower);
    end
  end
endmodule

// File: tb/sim_irq_best_sel.sv
module sim_irq_best_sel;
  localparam int VEC_W   = 32;
  localparam int NUM_SRC = 24;
  localparam int PRIO_W  = 3;
  localparam int ID_W    = $clog2(VEC_W);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic [VEC_W-1:0]        pend, claim, en;
  logic [VEC_W*PRIO_W-1:0] prio;
  logic [ID_W-1:0]         id;
  logic                    valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  string tag = "R2";

  irq_best_sel #(.VEC_W(VEC_W), .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u0 (
    .pend_i(pend), .claim_i(claim), .en_i(en), .prio_i(prio),
    .id_o(id), .valid_o(valid)
  );

  function automatic int ref_id();
    int best = 0;
    int bp = 0;
    for (int k = 1; k < NUM_SRC; k++) begin
      int p = int'(prio[k*PRIO_W +: PRIO_W]);
      if (pend[k] && en[k] && !claim[k] && (best == 0 || p > bp)) begin
        best = k;
        bp = p;
      end
    end
    return best;
  endfunction

  task automatic compare();
    int e = ref_id();
    n_cmp++;
    if (int'(id) != e || valid != (e != 0)) begin
      n_bad++;
      $display("FAIL %s: id=%0d valid=%0d expected id=%0d valid=%0d",
               tag, id, valid, e, (e != 0));
    end
  endtask

  task automatic apply(input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] c,
                       input logic [VEC_W-1:0] e, input logic [VEC_W*PRIO_W-1:0] pr);
    @(posedge clk_i);
    pend <= p; claim <= c; en <= e; prio <= pr;
    @(negedge clk_i);
    compare();
  endtask

  function automatic logic [VEC_W*PRIO_W-1:0] fill(input int v);
    logic [VEC_W*PRIO_W-1:0] r = '0;
    for (int k = 0; k < VEC_W; k++) r[k*PRIO_W +: PRIO_W] = PRIO_W'(v);
    return r;
  endfunction

  initial begin
    logic [VEC_W*PRIO_W-1:0] pr;
    pend = '0; claim = '0; en = '0; prio = '0;
    repeat (3) @(posedge clk_i);
    rst_ni <= 1'b1;
    @(negedge clk_i);
    tag = "R2"; compare();                                   // idle state
    // R1 masking, one term at a time on ID 5
    tag = "R1";
    apply(32'h20, 32'h0,  32'h20, fill(3));
    apply(32'h20, 32'h0,  32'h0,  fill(3));
    apply(32'h20, 32'h20, 32'h20, fill(3));
    apply(32'h0,  32'h0,  32'h20, fill(3));
    // R2 ID 0 never wins, even at top priority
    tag = "R2";
    pr = fill(1); pr[0 +: PRIO_W] = '1;
    apply(32'h1,  32'h0, 32'hFFFF_FFFF, pr);
    apply(32'h11, 32'h0, 32'hFFFF_FFFF, pr);
    // R3 highest priority wins irrespective of position
    tag = "R3";
    pr = fill(2); pr[9*PRIO_W +: PRIO_W] = 3'd6; pr[20*PRIO_W +: PRIO_W] = 3'd5;
    apply(32'h0010_0204, 32'h0, 32'hFFFF_FFFF, pr);
    // R4 ties to lowest ID; equal later source does not replace
    tag = "R4";
    apply(32'h0080_0880, 32'h0, 32'hFFFF_FFFF, fill(4));
    pr = fill(4); pr[7*PRIO_W +: PRIO_W] = 3'd5; pr[11*PRIO_W +: PRIO_W] = 3'd5;
    apply(32'h0080_0880, 32'h0, 32'hFFFF_FFFF, pr);
    // R5 priority zero candidates
    tag = "R5";
    apply(32'h0000_4000, 32'h0, 32'hFFFF_FFFF, fill(0));
    apply(32'h0040_4008, 32'h0, 32'hFFFF_FFFF, fill(0));
    // R6 stray bits above NUM_SRC with top priority
    tag = "R6";
    pr = fill(1); for (int k = NUM_SRC; k < VEC_W; k++) pr[k*PRIO_W +: PRIO_W] = '1;
    apply(32'hFF00_0000, 32'h0, 32'hFFFF_FFFF, pr);
    apply(32'hFF00_0040, 32'h0, 32'hFFFF_FFFF, pr);
    // R7 valid consistency on several candidate counts
    tag = "R7";
    apply(32'hFFFF_FFFE, 32'h0, 32'hFFFF_FFFF, fill(7));
    apply(32'h0, 32'h0, 32'h0, fill(7));
    // R8 change each input in consecutive cycles, compared every cycle
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      logic [VEC_W*PRIO_W-1:0] rp;
      for (int k = 0; k < VEC_W; k++) rp[k*PRIO_W +: PRIO_W] = PRIO_W'($urandom_range(0, 2));
      apply($urandom(), $urandom() & $urandom(), $urandom() | $urandom(), rp);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule